// File: doc/BRIEF.md
# Backlight Dimming PWM Generator

This block produces one pulse-width-modulated output for a display backlight. A prescaler divides the function clock into ticks. A period counter runs over those ticks, and the output is high for a programmed number of ticks at the start of each PWM cycle. Software sets up the block through a small register file: an enable bit, a prescaler field, a period field, a high-width field and a commit bit.

In the default build, software writes land in shadow copies. Writing 1 and then 0 to the commit bit marks the shadow set for transfer. The transfer into the working copies happens at the end of the PWM cycle in progress, so the waveform never shows a partial cycle. A build option removes the staging. In that build the working values follow the register contents directly. Reads always return the register contents that software wrote.

Top module: `bl_pwm`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is low.
- R2: Register map (byte offsets): enable at 0x00 (bit 0); commit at 0x08 (bit 0); prescaler at 0x10 (bits 25:16); period at 0x14 (bits 11:0) and high width at 0x14 (bits 28:16). Reads return the written field values, and every other bit reads zero.
- R3: One PWM cycle lasts (prescaler+1)×(period+1) clock cycles.
- R4: Each cycle starts with the output high for (prescaler+1)×high_width clock cycles, and the output is low for the rest of the cycle.
- R5: If high_width ≥ period+1, the output stays high continuously.
- R6: If high_width is 0, the output stays low continuously.
- R7: In the staged build, writes to the prescaler, period or high width do not change the waveform until a commit.
- R8: A commit (bit 0 of offset 0x08 written 1, then 0) lets the cycle in progress finish with the old values. The next cycle uses the new values.
- R9: Clearing enable drives the output low in the cycle after the write and returns both counters to zero. Setting enable again starts a fresh cycle with a full high phase.
- R10: In the direct build, writes change the waveform without any commit.
- R11: A commit issued while the block is disabled applies before the next enable, so the first cycle after enabling uses the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write takes effect at the clock edge that captures it. Enable, disable and the level of the first high phase are visible at the first sample after that edge, so those checks sample there. A commit becomes visible only at the next rising edge of the output after the cycle in progress ends. For that reason the scoreboard syncs to a rising edge, queues the old cycle's high and total length and then the new cycle's, and compares each rise-to-rise interval that the monitor measures. Read data is combinational and is checked one time step after the address is set.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   localparam int unsigned OFS_ENABLE = 32'h00;
   localparam int unsigned OFS_COMMIT = 32'h08;
   localparam int unsigned OFS_CTL0   = 32'h10;
   localparam int unsigned OFS_CTL1   = 32'h14;
   localparam int DIV_LSB = 16;
   localparam int PER_LSB = 0;
   localparam int HI_LSB  = 16;
   localparam int BUS_W   = 32;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
   import bl_pwm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIV_W  = 10,
   parameter int PER_W  = 12,
   parameter int HI_W   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              en,
   output logic              commit_pulse,
   output logic [DIV_W-1:0]  sh_div,
   output logic [PER_W-1:0]  sh_per,
   output logic [HI_W-1:0]   sh_hi
);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_CMT = ADDR_W'(OFS_COMMIT);
   localparam logic [ADDR_W-1:0] A_C0  = ADDR_W'(OFS_CTL0);
   localparam logic [ADDR_W-1:0] A_C1  = ADDR_W'(OFS_CTL1);

   logic commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en           <= 1'b0;
         commit_q     <= 1'b0;
         commit_pulse <= 1'b0;
         sh_div       <= '0;
         sh_per       <= '0;
         sh_hi        <= '0;
      end else begin
         commit_pulse <= 1'b0;
         if (wr) begin
            case (addr)
               A_EN:  en <= wdata[0];
               A_CMT: begin
                  commit_pulse <= wdata[0] & ~commit_q;
                  commit_q     <= wdata[0];
               end
               A_C0:  sh_div <= wdata[DIV_LSB +: DIV_W];
               A_C1: begin
                  sh_per <= wdata[PER_LSB +: PER_W];
                  sh_hi  <= wdata[HI_LSB +: HI_W];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_EN:  rdata[0] = en;
         A_CMT: rdata[0] = commit_q;
         A_C0:  rdata[DIV_LSB +: DIV_W] = sh_div;
         A_C1: begin
            rdata[PER_LSB +: PER_W] = sh_per;
            rdata[HI_LSB +: HI_W]   = sh_hi;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/bl_pwm_stage.sv
module bl_pwm_stage #(
   parameter int DIV_W    = 10,
   parameter int PER_W    = 12,
   parameter int HI_W     = 13,
   parameter bit BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             commit_pulse,
   input  logic             cycle_end,
   input  logic [DIV_W-1:0] sh_div,
   input  logic [PER_W-1:0] sh_per,
   input  logic [HI_W-1:0]  sh_hi,
   output logic [DIV_W-1:0] act_div,
   output logic [PER_W-1:0] act_per,
   output logic [HI_W-1:0]  act_hi,
   output logic             load_now
);
   generate
      if (BUFFERED) begin : g_staged
         logic pending;
         assign load_now = pending & (~en | cycle_end);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pending <= 1'b0;
               act_div <= '0;
               act_per <= '0;
               act_hi  <= '0;
            end else begin
               pending <= commit_pulse | (pending & ~load_now);
               if (load_now) begin
                  act_div <= sh_div;
                  act_per <= sh_per;
                  act_hi  <= sh_hi;
               end
            end
         end
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, en, commit_pulse, cycle_end};
         assign load_now  = 1'b0;
         assign act_div   = sh_div;
         assign act_per   = sh_per;
         assign act_hi    = sh_hi;
      end
   endgenerate
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
   parameter int DIV_W = 10,
   parameter int PER_W = 12,
   parameter int HI_W  = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] act_div,
   input  logic [PER_W-1:0] act_per,
   input  logic [HI_W-1:0]  act_hi,
   output logic [DIV_W-1:0] pre_cnt,
   output logic [PER_W-1:0] per_cnt,
   output logic             cycle_end,
   output logic             pwm_out
);
   logic tick, wrap;

   // >= keeps the counters bounded when the direct build shrinks a limit
   assign tick      = (pre_cnt >= act_div);
   assign wrap      = tick && (per_cnt >= act_per);
   assign cycle_end = en && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         per_cnt <= '0;
      end else if (!en) begin
         pre_cnt <= '0;
         per_cnt <= '0;
      end else if (tick) begin
         pre_cnt <= '0;
         per_cnt <= wrap ? '0 : per_cnt + 1'b1;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   assign pwm_out = en && (HI_W'(per_cnt) < act_hi);
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
   import bl_pwm_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DIV_W        = 10,
   parameter int PER_W        = 12,
   parameter int HI_W         = 13,
   parameter bit DIRECT_WRITE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              pwm_out
);
   localparam bit BUFFERED = !DIRECT_WRITE;

   generate
      if (DIV_W < 1 || DIV_LSB + DIV_W > BUS_W) begin : g_bad_div
         $error("prescaler field does not fit the register");
      end
      if (PER_W < 2 || PER_LSB + PER_W > HI_LSB) begin : g_bad_per
         $error("period field overlaps the high-width field");
      end
      if (HI_W <= PER_W || HI_LSB + HI_W > BUS_W) begin : g_bad_hi
         $error("high width must be wider than period and fit the register");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("address too narrow for the register map");
      end
   endgenerate

   logic             en_on, commit_pulse, cycle_end, load_now;
   logic [DIV_W-1:0] sh_div, act_div, pre_cnt;
   logic [PER_W-1:0] sh_per, act_per, per_cnt;
   logic [HI_W-1:0]  sh_hi, act_hi;

   bl_pwm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .en(en_on), .commit_pulse(commit_pulse),
      .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi)
   );

   bl_pwm_stage #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W), .BUFFERED(BUFFERED)) u_stage (
      .clk(clk), .rst_n(rst_n), .en(en_on), .commit_pulse(commit_pulse),
      .cycle_end(cycle_end), .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi),
      .act_div(act_div), .act_per(act_per), .act_hi(act_hi), .load_now(load_now)
   );

   bl_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en_on), .act_div(act_div), .act_per(act_per),
      .act_hi(act_hi), .pre_cnt(pre_cnt), .per_cnt(per_cnt),
      .cycle_end(cycle_end), .pwm_out(pwm_out)
   );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
   parameter int DIV_W    = 10,
   parameter int PER_W    = 12,
   parameter int HI_W     = 13,
   parameter bit BUFFERED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_on,
   input logic             load_now,
   input logic             pwm_out,
   input logic [DIV_W-1:0] pre_cnt,
   input logic [PER_W-1:0] per_cnt,
   input logic [DIV_W-1:0] act_div,
   input logic [PER_W-1:0] act_per,
   input logic [HI_W-1:0]  act_hi
);
   // R9
   pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_on |-> !pwm_out);

   // R9
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_on |=> (pre_cnt == '0 && per_cnt == '0));

   // R6
   hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_hi == '0) |-> !pwm_out);

   generate
      if (BUFFERED) begin : g_staged_chk
         // R5
         full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_on && act_hi > HI_W'(act_per)) |-> pwm_out);

         // R8
         act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load_now |=> ($stable(act_div) && $stable(act_per) && $stable(act_hi)));

         // R3
         cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_cnt <= act_div && per_cnt <= act_per));
      end
   endgenerate
endmodule

bind bl_pwm bl_pwm_chk #(
   .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W), .BUFFERED(!DIRECT_WRITE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_on(en_on), .load_now(load_now), .pwm_out(pwm_out),
   .pre_cnt(pre_cnt), .per_cnt(per_cnt), .act_div(act_div), .act_per(act_per),
   .act_hi(act_hi)
);

// File: tb/bl_pwm_test.sv
module bl_pwm_test;
   typedef struct {
      int    hi;
      int    len;
      string req;
   } cyc_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_b, rdata_d;
   logic        pwm_b, pwm_d;

   int   nchk = 0;
   int   nfail = 0;
   bit   done = 1'b0;
   cyc_t exp_q[$];

   always #4 clk = ~clk;

   bl_pwm uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pwm_out(pwm_b)
   );

   bl_pwm #(.DIRECT_WRITE(1'b1)) uut_dir (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_d), .pwm_out(pwm_d)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic commit();
      wr(8'h08, 32'h1);
      wr(8'h08, 32'h0);
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(rdata_b == exp, req, rdata_b, exp);
   endtask

   task automatic wait_rise();
      logic p;
      p = pwm_b;
      forever begin
         @(negedge clk);
         if (pwm_b && !p) break;
         p = pwm_b;
      end
   endtask

   task automatic push(input int hi, input int len, input string req);
      cyc_t c;
      c.hi = hi; c.len = len; c.req = req;
      exp_q.push_back(c);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic count_high(output int n);
      n = 0;
      while (pwm_b) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic level_count(input bit use_dir, input int nsmp, output int n);
      n = 0;
      for (int i = 0; i < nsmp; i++) begin
         @(negedge clk);
         n += use_dir ? int'(pwm_d) : int'(pwm_b);
      end
   endtask

   // monitor: measures each rise-to-rise interval of the staged instance
   initial begin
      bit started = 1'b0;
      bit prev = 1'b0;
      int hcnt = 0;
      int len = 0;
      forever begin
         @(negedge clk);
         if (pwm_b && !prev) begin
            if (started && exp_q.size() != 0) begin
               cyc_t e;
               e = exp_q.pop_front();
               chk(hcnt == e.hi, {e.req, " high length"}, hcnt, e.hi);
               chk(len == e.len, {e.req, " cycle length"}, len, e.len);
            end
            started = 1'b1;
            hcnt = 1;
            len = 1;
         end else if (started) begin
            len++;
            if (pwm_b) hcnt++;
         end
         prev = pwm_b;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (5) @(negedge clk);
      chk(pwm_b == 1'b0, "R1 output", pwm_b, 0);
      rst_n = 1'b1;
      rd_chk(8'h00, 32'h0, "R1 enable");
      rd_chk(8'h08, 32'h0, "R1 commit");
      rd_chk(8'h10, 32'h0, "R1 ctl0");
      rd_chk(8'h14, 32'h0, "R1 ctl1");

      // R2 field masking on readback
      wr(8'h10, 32'hFFFF_FFFF);
      rd_chk(8'h10, 32'h03FF_0000, "R2 ctl0");
      wr(8'h14, 32'hFFFF_FFFF);
      rd_chk(8'h14, 32'h1FFF_0FFF, "R2 ctl1");
      wr(8'h00, 32'hFFFF_FFFE);
      rd_chk(8'h00, 32'h0, "R2 enable");
      chk(pwm_b == 1'b0, "R2 enable bit0 clear", pwm_b, 0);

      // R3 R4: prescaler 0, period 6, high 3 -> 7 cycles, 3 high
      wr(8'h10, 32'h0);
      wr(8'h14, (32'd3 << 16) | 32'd6);
      commit();
      wr(8'h00, 32'h1);
      repeat (20) @(negedge clk);
      push(3, 7, "R3/R4 base");
      push(3, 7, "R4 repeat");
      drain();

      // R7: staged writes without commit leave the waveform alone
      wr(8'h10, 32'd2 << 16);
      wr(8'h14, (32'd1 << 16) | 32'd3);
      repeat (20) @(negedge clk);
      push(3, 7, "R7 no commit");
      drain();

      // R10: direct build already runs 12-cycle period with 3 high
      repeat (30) @(negedge clk);
      level_count(1'b1, 24, n);
      chk(n == 6, "R10 direct high count", n, 6);

      // R8: commit right after a cycle start
      wait_rise();
      commit();
      push(3, 7, "R8 old cycle intact");
      push(3, 12, "R8 new cycle");
      push(3, 12, "R3 prescaled cycle");
      drain();

      // R5: high width equal to period+1
      wr(8'h14, (32'd4 << 16) | 32'd3);
      commit();
      repeat (30) @(negedge clk);
      level_count(1'b0, 24, n);
      chk(n == 24, "R5 always high", n, 24);

      // R6: zero high width
      wr(8'h14, 32'd3);
      commit();
      repeat (30) @(negedge clk);
      level_count(1'b0, 24, n);
      chk(n == 0, "R6 always low", n, 0);

      // R9: prescaler 1, period 3, high 2 -> 8 cycles, 4 high
      wr(8'h10, 32'd1 << 16);
      wr(8'h14, (32'd2 << 16) | 32'd3);
      commit();
      repeat (40) @(negedge clk);
      wait_rise();
      wr(8'h00, 32'h0);
      chk(pwm_b == 1'b0, "R9 low after disable", pwm_b, 0);
      level_count(1'b0, 10, n);
      chk(n == 0, "R9 stays low", n, 0);
      wr(8'h00, 32'h1);
      count_high(n);
      chk(n == 4, "R9 fresh high phase", n, 4);

      // R11: commit while disabled
      wr(8'h00, 32'h0);
      wr(8'h10, 32'h0);
      wr(8'h14, (32'd1 << 16) | 32'd1);
      commit();
      wr(8'h00, 32'h1);
      count_high(n);
      chk(n == 1, "R11 first high phase", n, 1);
      repeat (10) @(negedge clk);
      push(1, 2, "R11 cycle");
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule